// File: doc/BRIEF.md
# Asynchronous Non-Volatile Byte Memory Bus Controller

This block sits between a synchronous host and a byte-wide non-volatile memory that uses SRAM-style asynchronous control. The memory has a 19-bit address (524,288 byte locations), an 8-bit data bus, and three active-low strobes: select, write strobe and output strobe. The host presents one request at a time with a valid/ready handshake. A read returns its byte through a one-cycle response strobe. The controller turns each accepted request into a strobe sequence that meets the memory's minimum times. It counts every interval in clock cycles. Each count is derived when the block is built from the clock period and the time that interval needs.

A central state machine owns the strobes and the data-driver enable. An interval timer counts down each timed phase. A bus-path stage holds the address and write data steady for the whole access and captures read data. The data pins themselves are outside the block: it provides the outgoing byte, a driver-enable and the incoming byte.

States: `ST_IDLE` (ready, all strobes inactive), `ST_WR_TURN` (bus settle after a read), `ST_WR_SETUP` (select low, data driven), `ST_WR_PULSE` (select and write strobe low), `ST_WR_RECOV` (strobes high, address and data held), `ST_RD_ACCESS` (select and output strobe low). Transitions:
- `ST_IDLE` goes to `ST_RD_ACCESS` on a read.
- `ST_IDLE` goes to `ST_WR_TURN` on a write that follows a read, and to `ST_WR_SETUP` on any other write.
- `ST_WR_TURN` goes to `ST_WR_SETUP` when its count ends.
- `ST_WR_SETUP` goes to `ST_WR_PULSE` after one cycle.
- `ST_WR_PULSE` goes to `ST_WR_RECOV` when its count ends.
- `ST_WR_RECOV` goes to `ST_IDLE` when its count ends.
- `ST_RD_ACCESS` goes to `ST_IDLE` when its count ends, capturing the data.

Top module: `async_nvram_ctrl`

## Requirements
- R1: While reset is held, and right after it, `req_ready` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the sequence ends. A request held while `req_ready` is 0 starts no memory activity.
- R3: A write drives `mem_ce_n` low for one setup cycle with `mem_we_n` high. Then `mem_ce_n` and `mem_we_n` are both low for WP_N cycles. Then both are high for REC_N recovery cycles, with address and data held, before `req_ready` returns. `mem_we_n` is never low while `mem_ce_n` is high.
- R4: During a write `mem_oe_n` stays 1. `mem_dq_oe` is 1 and `mem_dq_out` is stable for the whole time `mem_we_n` is 0, and the stored byte is `req_wdata`.
- R5: A read holds `mem_ce_n` and `mem_oe_n` at 0 and `mem_we_n` at 1 for ACC_N cycles. It samples `mem_dq_in` at the last of them. `rsp_valid` is then 1 for exactly one cycle with that byte on `rsp_rdata`.
- R6: A write accepted after a read waits OFF_N cycles in `ST_WR_TURN` before `mem_dq_oe` rises. No rise of `mem_dq_oe` comes fewer than OFF_N cycles after `mem_oe_n` rises.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R8: `mem_addr` does not change while `mem_ce_n` stays 0.
- R9: Between two falling edges of `mem_ce_n` there are at least CYC_N cycles, and `mem_ce_n` is high for at least one cycle in between.
- R10: Every count is ceil(time / clock period), and never below 1. At the default 20 ns clock this gives CYC_N=2, ACC_N=2, WP_N=1, REC_N=1 and OFF_N=1. A write holds `req_ready` low for 3 cycles (4 after a read) and a read for 2.
- R11: Every address from 0x00000 to 0x7FFFF reaches `mem_addr` unchanged, including both ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 19 | Memory address pins |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output strobe, active low |
| mem_dq_out | output | 8 | Byte for the data pins |
| mem_dq_oe | output | 1 | Enable for the controller's data driver |
| mem_dq_in | input | 8 | Byte read back from the data pins |

## Verification
A state register stuck or skipping a phase shows at the strobes within one or two cycles. The write-strobe low window gets the wrong length, `req_ready` returns early or late, or `mem_oe_n` and `mem_dq_oe` overlap. Each of these is measured at the pins against the counts derived from the 20 ns clock. A lost turnaround or read-history flag shows only on the first write after a read, as one cycle less of busy time, so the bench mixes reads and writes back to back. A timer that loads wrong shows as a response strobe that arrives off its expected cycle, or as stale captured data. The bench tells a stale byte apart by writing distinct values to the address-range ends and rewriting one location.

// File: rtl/nvram_ctrl_pkg.sv
package nvram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_RD_ACCESS
    } ctrl_state_e;

    // ceil(time / period), never below one cycle
    function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                                 input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nvram_interval_timer.sv
module nvram_interval_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // a load of N keeps the phase for N cycles (count N-1 .. 0)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/nvram_bus_path.sv
module nvram_bus_path #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    // address and write byte held for the whole access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // read byte captured at the end of the access count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) begin
                rsp_rdata <= mem_dq_in;
            end
        end
    end

endmodule

// File: rtl/nvram_seq_fsm.sv
module nvram_seq_fsm
    import nvram_ctrl_pkg::*;
#(
    parameter int CNT_W = 2,
    parameter int ACC_N = 2,
    parameter int WP_N  = 1,
    parameter int REC_N = 1,
    parameter int OFF_N = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             tmr_expired,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe
);

    localparam logic [CNT_W-1:0] ACC_V = CNT_W'(ACC_N);
    localparam logic [CNT_W-1:0] WP_V  = CNT_W'(WP_N);
    localparam logic [CNT_W-1:0] REC_V = CNT_W'(REC_N);
    localparam logic [CNT_W-1:0] OFF_V = CNT_W'(OFF_N);

    ctrl_state_e state_q, state_d;
    logic        rd_last_q, rd_last_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rd_last_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            rd_last_q <= rd_last_d;
        end
    end

    // transitions
    always_comb begin
        state_d   = state_q;
        rd_last_d = rd_last_q;
        accept    = 1'b0;
        capture   = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        if (rd_last_q) begin
                            state_d  = ST_WR_TURN;
                            tmr_load = 1'b1;
                            tmr_val  = OFF_V;
                        end else begin
                            state_d = ST_WR_SETUP;
                        end
                    end else begin
                        state_d  = ST_RD_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = ACC_V;
                    end
                end
            end
            ST_WR_TURN: begin
                if (tmr_expired) begin
                    state_d = ST_WR_SETUP;
                end
            end
            ST_WR_SETUP: begin
                state_d   = ST_WR_PULSE;
                rd_last_d = 1'b0;
                tmr_load  = 1'b1;
                tmr_val   = WP_V;
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = REC_V;
                end
            end
            ST_WR_RECOV: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    state_d   = ST_IDLE;
                    capture   = 1'b1;
                    rd_last_d = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // strobes and driver enable per state
    always_comb begin
        req_ready = 1'b0;
        ce_n      = 1'b1;
        we_n      = 1'b1;
        oe_n      = 1'b1;
        dq_oe     = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_WR_TURN:   dq_oe     = 1'b0;
            ST_WR_SETUP: begin
                ce_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                ce_n  = 1'b0;
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            ST_WR_RECOV:  dq_oe = 1'b1;
            ST_RD_ACCESS: begin
                ce_n = 1'b0;
                oe_n = 1'b0;
            end
            default: req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/async_nvram_ctrl.sv
module async_nvram_ctrl
    import nvram_ctrl_pkg::*;
#(
    parameter int ADDR_W          = 19,
    parameter int DATA_W          = 8,
    parameter int CLK_PERIOD_PS   = 20000,
    parameter int T_CYCLE_PS      = 35000,
    parameter int T_ADDR_ACC_PS   = 35000,
    parameter int T_OE_ACC_PS     = 15000,
    parameter int T_WPULSE_PS     = 15000,
    parameter int T_DSETUP_PS     = 10000,
    parameter int T_ADDR_END_PS   = 20000,
    parameter int T_WRECOV_PS     = 12000,
    parameter int T_OE_OFF_PS     = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned CLK_PS = CLK_PERIOD_PS;
    localparam int unsigned CYC_N  = ps_to_cycles(T_CYCLE_PS, CLK_PS);
    // read: longest of address access, output access and cycle time
    localparam int unsigned ACC_N  = max_u(max_u(ps_to_cycles(T_ADDR_ACC_PS, CLK_PS),
                                                 ps_to_cycles(T_OE_ACC_PS, CLK_PS)), CYC_N);
    // write: setup cycle counts toward address/data lead time
    localparam int unsigned AEND_N = ps_to_cycles(T_ADDR_END_PS, CLK_PS);
    localparam int unsigned DSET_N = ps_to_cycles(T_DSETUP_PS, CLK_PS);
    localparam int unsigned WP_N   = max_u(ps_to_cycles(T_WPULSE_PS, CLK_PS),
                                           max_u((AEND_N > 1) ? AEND_N - 1 : 1,
                                                 (DSET_N > 1) ? DSET_N - 1 : 1));
    localparam int unsigned TAIL_N = (CYC_N > WP_N + 1) ? CYC_N - WP_N - 1 : 1;
    localparam int unsigned REC_N  = max_u(ps_to_cycles(T_WRECOV_PS, CLK_PS), TAIL_N);
    localparam int unsigned OFF_N  = ps_to_cycles(T_OE_OFF_PS, CLK_PS);
    localparam int unsigned CNT_MX = max_u(max_u(ACC_N, WP_N), max_u(REC_N, OFF_N));
    localparam int          CNT_W  = (CNT_MX < 2) ? 1 : $clog2(CNT_MX + 1);

    logic             accept;
    logic             capture;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;

    nvram_seq_fsm #(
        .CNT_W (CNT_W),
        .ACC_N (int'(ACC_N)),
        .WP_N  (int'(WP_N)),
        .REC_N (int'(REC_N)),
        .OFF_N (int'(OFF_N))
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .tmr_expired (tmr_expired),
        .req_ready   (req_ready),
        .accept      (accept),
        .capture     (capture),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .ce_n        (mem_ce_n),
        .we_n        (mem_we_n),
        .oe_n        (mem_oe_n),
        .dq_oe       (mem_dq_oe)
    );

    nvram_interval_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    nvram_bus_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .capture    (capture),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: rtl/nvram_ctrl_checker.sv
module nvram_ctrl_checker #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int OFF_N  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              rsp_valid
);

    // cycles since the output strobe was last low, saturating
    logic [15:0] off_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_cnt <= 16'(OFF_N);
        end else if (!mem_oe_n) begin
            off_cnt <= '0;
        end else if (off_cnt < 16'(OFF_N)) begin
            off_cnt <= off_cnt + 16'd1;
        end
    end

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);                               // R2
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);                                               // R3
    AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);                                                // R4
    AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);                                               // R4
    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));               // R4
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                              // R5
    AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (off_cnt >= 16'(OFF_N)));                          // R6
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);                                              // R7
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));                 // R8

endmodule

bind async_nvram_ctrl nvram_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFF_N  (int'(OFF_N))
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_oe  (mem_dq_oe),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid)
);

// File: tb/test_async_nvram_ctrl.sv
module test_async_nvram_ctrl;

    // counts expected at a 20 ns clock: ceil(t/20ns), at least 1
    localparam int EXP_ACC  = 2;  // 35 ns
    localparam int EXP_WP   = 1;  // max(15, 20-20, 10-20)
    localparam int EXP_REC  = 1;  // max(12 ns, cycle tail)
    localparam int EXP_OFF  = 1;  // 10 ns
    localparam int EXP_CYC  = 2;  // 35 ns

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int n_checks = 0;
    int n_fail   = 0;
    bit last_rd  = 1'b0;

    always #10 clk = ~clk;

    async_nvram_ctrl i_async_nvram_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: store during select+write overlap, drive on read
    logic [7:0] mdl [logic [18:0]];
    always @(negedge clk) begin
        if (rst_n && !mem_ce_n && !mem_we_n) mdl[mem_addr] = mem_dq_out;
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_in <= mdl.exists(mem_addr) ? mdl[mem_addr] : 8'hA5;
        else
            mem_dq_in <= 8'hEE;
    end

    // write-strobe window monitor
    int we_run = 0;
    bit wr_bad = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) begin
                we_run++;
                if (mem_oe_n !== 1'b1 || mem_dq_oe !== 1'b1 || mem_ce_n !== 1'b0) wr_bad = 1'b1;
            end else if (we_run != 0) begin
                check(we_run == EXP_WP, "R3 write pulse cycles", we_run, EXP_WP);
                check(!wr_bad, "R4 oe high, driver on, select low during write", wr_bad, 0);
                we_run = 0;
                wr_bad = 1'b0;
            end
        end
    end

    // select spacing and address hold
    int   since_fall = 0;
    bit   seen_fall  = 1'b0;
    logic prev_ce    = 1'b1;
    logic [18:0] prev_addr = '0;
    int   addr_moves = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            since_fall++;
            if (!mem_ce_n && prev_ce) begin
                if (seen_fall)
                    check(since_fall >= EXP_CYC + 1, "R9 select-to-select spacing", since_fall, EXP_CYC + 1);
                seen_fall  = 1'b1;
                since_fall = 0;
            end
            if (!mem_ce_n && !prev_ce && mem_addr != prev_addr) addr_moves++;
        end
        prev_ce   = mem_ce_n;
        prev_addr = mem_addr;
    end

    // one request; returns the number of negedges until ready is back
    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d,
                         output int n, output int rsp_at, output logic [7:0] rdat);
        while (req_ready !== 1'b1) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        n = 0;
        rsp_at = 0;
        rdat = 8'h00;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                req_valid = 1'b0;
                check(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
            end
            if (rsp_valid) begin
                rsp_at = n;
                rdat = rsp_rdata;
            end
            if (req_ready || n > 40) break;
        end
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        int n, ra;
        logic [7:0] rd;
        int exp_n;
        exp_n = 1 + 1 + EXP_WP + EXP_REC + (last_rd ? EXP_OFF : 0);
        issue(1'b1, a, d, n, ra, rd);
        check(n == exp_n, last_rd ? "R6 R10 write busy after read" : "R3 R10 write busy",
              n, exp_n);
        check(mdl.exists(a) && mdl[a] == d, "R4 R11 stored byte", mdl.exists(a) ? mdl[a] : 0, d);
        last_rd = 1'b0;
    endtask

    task automatic do_read(input logic [18:0] a, input logic [7:0] e);
        int n, ra;
        logic [7:0] rd;
        issue(1'b0, a, 8'h00, n, ra, rd);
        check(ra == EXP_ACC + 1, "R5 R10 response cycle", ra, EXP_ACC + 1);
        check(rd == e, "R5 R11 read data", rd, e);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R5 response one cycle", rsp_valid, 0);
        last_rd = 1'b1;
    endtask

    // write flag, 19-bit address, byte (expected byte for reads)
    localparam logic [27:0] VEC [10] = '{
        {1'b1, 19'h00000, 8'h3C},
        {1'b1, 19'h7FFFF, 8'hC3},
        {1'b1, 19'h12345, 8'h5A},
        {1'b0, 19'h00000, 8'h3C},
        {1'b0, 19'h7FFFF, 8'hC3},
        {1'b1, 19'h12345, 8'hA7},
        {1'b0, 19'h12345, 8'hA7},
        {1'b1, 19'h40000, 8'h01},
        {1'b0, 19'h40000, 8'h01},
        {1'b0, 19'h7FFFF, 8'hC3}
    };

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        check({mem_ce_n, mem_we_n, mem_oe_n} == 3'b111, "R1 strobes in reset",
              {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        check(mem_dq_oe == 1'b0, "R1 driver off in reset", mem_dq_oe, 0);
        check(rsp_valid == 1'b0, "R1 no response in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && mem_ce_n == 1'b1, "R1 idle after reset",
              {req_ready, mem_ce_n}, 2'b11);

        for (int i = 0; i < 10; i++) begin
            if (VEC[i][27]) do_write(VEC[i][26:8], VEC[i][7:0]);
            else            do_read(VEC[i][26:8], VEC[i][7:0]);
        end

        // R2: a request held while busy starts nothing
        begin
            int quiet;
            while (req_ready !== 1'b1) @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00055; req_wdata = 8'h99;
            @(negedge clk);
            req_write = 1'b0; req_addr = 19'h00000;   // held read while busy
            @(negedge clk);
            req_valid = 1'b0;
            while (req_ready !== 1'b1) @(negedge clk);
            quiet = 0;
            for (int k = 0; k < 4; k++) begin
                if (mem_ce_n == 1'b1 && rsp_valid == 1'b0) quiet++;
                @(negedge clk);
            end
            check(quiet == 4, "R2 held request while busy ignored", quiet, 4);
            check(mdl.exists(19'h00055) && mdl[19'h00055] == 8'h99, "R2 write still completes",
                  mdl.exists(19'h00055) ? mdl[19'h00055] : 0, 8'h99);
            last_rd = 1'b0;
        end

        // R6: read immediately followed by write to the same location
        do_read(19'h00055, 8'h99);
        do_write(19'h00055, 8'h66);
        do_read(19'h00055, 8'h66);

        // R11 boundary: top address rewritten, bottom untouched
        do_write(19'h7FFFF, 8'hFF);
        do_read(19'h7FFFF, 8'hFF);
        do_read(19'h00000, 8'h3C);

        repeat (4) @(negedge clk);
        check(addr_moves == 0, "R8 address held while selected", addr_moves, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule